// File: doc/BRIEF.md
# Multiprocessor-Addressed Serial Port

This block is a full-duplex asynchronous serial port that a host drives through four byte-wide registers. It sends and receives frames of either eight or nine data bits. A separate one-cycle strobe sets the rate: `baud_tick` pulses at sixteen times the bit rate. The receiver oversamples the line and decides each bit by a vote of three samples. The transmitter shifts out a frame loaded by a host write and raises a completion flag as the final line-high bit begins.

In nine-bit mode the receiver can act as a node on a shared multidrop line. A received byte whose ninth bit is high is treated as an address. It is passed to the host only if it matches the node's own address under a mask, or matches the group broadcast pattern. Every other frame is silently dropped while this filtering is on. A frame that ends without a high stop bit raises a sticky error flag.

The register port is a plain write strobe with a combinational read mux, so it has no back-pressure. A data write while the transmitter is busy is discarded. A completed receive frame is dropped if the host has not yet cleared the receive flag. Register index 0 is data (write: transmit, read: received byte), 1 is control/status, 2 is own address, 3 is address mask.

Top module: `mp_uart`

## Requirements
- R1: After reset, `txd` is 1, `rx_irq` and `tx_irq` are 0, and the control register reads 0x00.
- R2: A data write while idle sends a start bit of 0, then the eight data bits LSB first, then (only when control bit 6 is 1) control bit 3 as a ninth bit, then a stop bit of 1, each bit 16 ticks long; `txd` is 1 whenever nothing is being sent.
- R3: The transmit flag (control bit 1, also `tx_irq`) is set in the same cycle that the stop bit starts on `txd`; a data write while a frame is in flight is ignored.
- R4: With control bit 5 (receive enable) set and bit 6 clear, a 10-bit frame on `rxd` puts its byte in the data register, its stop bit in control bit 4, and sets control bit 0 (`rx_irq`).
- R5: With control bit 6 set, frames are 11 bits, and the received ninth bit goes to control bit 4.
- R6: With control bits 6 and 7 both set, a frame whose ninth bit is 0 leaves the receive flag and data register unchanged.
- R7: In that mode, a frame with ninth bit 1 is accepted when (byte XOR own address) AND mask is zero; otherwise it is dropped.
- R8: In that mode, a frame with ninth bit 1 is also accepted when it holds a 1 in every position where (own address OR mask) is 1.
- R9: A stop bit sampled as 0 sets control bit 2, which stays set until the host writes 0 to it; bits 0, 1 and 2 of control take the written value.
- R10: Each bit is the majority of three samples taken at mid-bit. A start bit whose midpoint votes 1 is discarded, and a glitch of one tick inside a bit does not change the received value.
- R11: A frame that completes while control bit 0 is still set is discarded, and the data register keeps the earlier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe at 16x bit rate |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_irq | output | 1 | Receive flag |
| tx_irq | output | 1 | Transmit flag |

## Verification
The hardest conditions to reach are the ones where the receiver must refuse a frame that looks correct on the wire. These are a good frame that arrives while the earlier byte is still unread, an address frame that misses both the masked match and the broadcast pattern, and a start pulse too short to survive the mid-bit vote. The stimulus reaches them by driving `rxd` bit by bit, holding back the flag clear between frames, and giving a narrow low pulse or a one-tick glitch inside a data bit. After each refused frame, the data register and receive flag are read back to show they were left unchanged.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  typedef enum logic [1:0] {
    RG_DATA = 2'd0,
    RG_CTRL = 2'd1,
    RG_OWN  = 2'd2,
    RG_MASK = 2'd3
  } reg_sel_e;

  localparam int CB_RXF   = 0;
  localparam int CB_TXF   = 1;
  localparam int CB_FERR  = 2;
  localparam int CB_TXB9  = 3;
  localparam int CB_RXB9  = 4;
  localparam int CB_RXEN  = 5;
  localparam int CB_MODE9 = 6;
  localparam int CB_MPEN  = 7;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_STOP} tx_state_e;
endpackage

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_uart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          mode9,
  input  logic          rxd,
  output logic          fire,
  output logic [DW-1:0] data,
  output logic          b9,
  output logic          stop_ok
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 2);
  localparam logic [CW-1:0] S_A  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] S_B  = CW'(OSR / 2);
  localparam logic [CW-1:0] S_C  = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [1:0]    sync_q;
  logic          line;
  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [BW-1:0] bit_last;
  logic [1:0]    smp_q;
  logic          vote;
  logic [DW:0]   sh_q;

  assign line     = sync_q[1];
  assign vote     = (smp_q[0] & smp_q[1]) | (smp_q[0] & line) | (smp_q[1] & line);
  assign bit_last = mode9 ? BW'(DW) : BW'(DW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      smp_q   <= '0;
      sh_q    <= '0;
      fire    <= 1'b0;
      data    <= '0;
      b9      <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (tick) begin
        if (st_q == RX_IDLE) begin
          if (en && !line) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
        end else begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == S_A) smp_q[0] <= line;
          if (cnt_q == S_B) smp_q[1] <= line;
          unique case (st_q)
            RX_START: begin
              if (cnt_q == S_C && vote) st_q <= RX_IDLE;
              else if (cnt_q == LAST) begin
                st_q  <= RX_DATA;
                bit_q <= '0;
              end
            end
            RX_DATA: begin
              if (cnt_q == S_C) sh_q <= {vote, sh_q[DW:1]};
              if (cnt_q == LAST) begin
                if (bit_q == bit_last) st_q <= RX_STOP;
                else bit_q <= bit_q + 1'b1;
              end
            end
            RX_STOP: begin
              if (cnt_q == S_C) begin
                st_q    <= RX_IDLE;
                fire    <= 1'b1;
                stop_ok <= vote;
                if (mode9) begin
                  data <= sh_q[DW-1:0];
                  b9   <= sh_q[DW];
                end else begin
                  data <= sh_q[DW:1];
                  b9   <= vote;
                end
              end
            end
            default: st_q <= RX_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
  import mp_uart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  logic          mode9,
  input  logic          b9,
  output logic          txd,
  output logic          busy,
  output logic          stop_begin
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  tx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] left_q;
  logic [DW:0]   sh_q;
  logic          bit_end;

  assign busy       = (st_q != TX_IDLE);
  assign bit_end    = tick && (cnt_q == LAST);
  assign stop_begin = (st_q == TX_SHIFT) && bit_end && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      left_q <= '0;
      sh_q   <= '0;
      txd    <= 1'b1;
    end else begin
      if (busy && tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      unique case (st_q)
        TX_IDLE: begin
          if (start) begin
            st_q   <= TX_SHIFT;
            txd    <= 1'b0;
            cnt_q  <= '0;
            sh_q   <= {b9, data};
            left_q <= mode9 ? BW'(DW + 1) : BW'(DW);
          end
        end
        TX_SHIFT: begin
          if (bit_end) begin
            if (left_q == '0) begin
              st_q <= TX_STOP;
              txd  <= 1'b1;
            end else begin
              txd    <= sh_q[0];
              sh_q   <= {1'b0, sh_q[DW:1]};
              left_q <= left_q - 1'b1;
            end
          end
        end
        TX_STOP: if (bit_end) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mp_uart_match.sv
module mp_uart_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] own,
  input  logic [DW-1:0] mask,
  input  logic          b9,
  input  logic          filter_on,
  output logic          accept
);
  logic own_hit;
  logic group_hit;

  assign own_hit   = ((rx_byte ^ own) & mask) == '0;
  assign group_hit = ((~rx_byte) & (own | mask)) == '0;
  assign accept    = !filter_on || (b9 && (own_hit || group_hit));
endmodule

// File: rtl/mp_uart.sv
module mp_uart
  import mp_uart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          rxd,
  output logic          txd,
  output logic          rx_irq,
  output logic          tx_irq
);
  logic          rxf_q, txf_q, ferr_q, txb9_q, rxb9_q, rxen_q, mode9_q, mpen_q;
  logic [DW-1:0] rx_buf_q, own_q, mask_q;
  logic [DW-1:0] ctrl_rd;
  logic          wr_data, wr_ctrl;
  logic          tx_busy, tx_stop_begin, tx_go;
  logic          rx_fire, rx_b9, rx_stop, rx_accept, rx_take;
  logic [DW-1:0] rx_byte;

  assign wr_data = reg_wr && (reg_sel_e'(reg_addr) == RG_DATA);
  assign wr_ctrl = reg_wr && (reg_sel_e'(reg_addr) == RG_CTRL);
  assign tx_go   = wr_data && !tx_busy;
  assign rx_take = rx_fire && !rxf_q && rx_accept;

  mp_uart_tx #(.OSR(OSR), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(tx_go),
    .data(reg_wdata), .mode9(mode9_q), .b9(txb9_q),
    .txd(txd), .busy(tx_busy), .stop_begin(tx_stop_begin)
  );

  mp_uart_rx #(.OSR(OSR), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rxen_q),
    .mode9(mode9_q), .rxd(rxd), .fire(rx_fire), .data(rx_byte),
    .b9(rx_b9), .stop_ok(rx_stop)
  );

  mp_uart_match #(.DW(DW)) u_match (
    .rx_byte(rx_byte), .own(own_q), .mask(mask_q), .b9(rx_b9),
    .filter_on(mode9_q && mpen_q), .accept(rx_accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_q <= 1'b0; txf_q <= 1'b0; ferr_q <= 1'b0; txb9_q <= 1'b0;
      rxb9_q <= 1'b0; rxen_q <= 1'b0; mode9_q <= 1'b0; mpen_q <= 1'b0;
      rx_buf_q <= '0; own_q <= '0; mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        rxf_q   <= reg_wdata[CB_RXF];
        txf_q   <= reg_wdata[CB_TXF];
        ferr_q  <= reg_wdata[CB_FERR];
        txb9_q  <= reg_wdata[CB_TXB9];
        rxen_q  <= reg_wdata[CB_RXEN];
        mode9_q <= reg_wdata[CB_MODE9];
        mpen_q  <= reg_wdata[CB_MPEN];
      end
      if (reg_wr && reg_sel_e'(reg_addr) == RG_OWN)  own_q  <= reg_wdata;
      if (reg_wr && reg_sel_e'(reg_addr) == RG_MASK) mask_q <= reg_wdata;
      if (tx_stop_begin) txf_q <= 1'b1;
      if (rx_fire && !rx_stop) ferr_q <= 1'b1;
      if (rx_take) begin
        rxf_q    <= 1'b1;
        rx_buf_q <= rx_byte;
        rxb9_q   <= rx_b9;
      end
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[CB_RXF]   = rxf_q;
    ctrl_rd[CB_TXF]   = txf_q;
    ctrl_rd[CB_FERR]  = ferr_q;
    ctrl_rd[CB_TXB9]  = txb9_q;
    ctrl_rd[CB_RXB9]  = rxb9_q;
    ctrl_rd[CB_RXEN]  = rxen_q;
    ctrl_rd[CB_MODE9] = mode9_q;
    ctrl_rd[CB_MPEN]  = mpen_q;
    unique case (reg_sel_e'(reg_addr))
      RG_DATA: reg_rdata = rx_buf_q;
      RG_CTRL: reg_rdata = ctrl_rd;
      RG_OWN:  reg_rdata = own_q;
      default: reg_rdata = mask_q;
    endcase
  end

  assign rx_irq = rxf_q;
  assign tx_irq = txf_q;
endmodule

// File: rtl/mp_uart_chk.sv
module mp_uart_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          rx_irq,
  input logic          tx_irq,
  input logic          tx_busy,
  input logic          tx_stop_begin,
  input logic          rx_fire,
  input logic          rx_stop,
  input logic          rx_b9,
  input logic          mode9_q,
  input logic          mpen_q,
  input logic          rxf_q,
  input logic          ferr_q,
  input logic [DW-1:0] rx_buf_q,
  input logic          reg_wr,
  input logic [1:0]    reg_addr
);
  // R2
  txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R3
  tx_flag_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop_begin |=> (txd && tx_irq));

  // R9
  ferr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !rx_stop) |=> ferr_q);

  // R6
  mp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && mode9_q && mpen_q && !rx_b9 && !(reg_wr && reg_addr == 2'd1))
      |=> $stable(rx_irq));

  // R11
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && rxf_q) |=> $stable(rx_buf_q));
endmodule

bind mp_uart mp_uart_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .rx_irq(rx_irq), .tx_irq(tx_irq),
  .tx_busy(tx_busy), .tx_stop_begin(tx_stop_begin), .rx_fire(rx_fire),
  .rx_stop(rx_stop), .rx_b9(rx_b9), .mode9_q(mode9_q), .mpen_q(mpen_q),
  .rxf_q(rxf_q), .ferr_q(ferr_q), .rx_buf_q(rx_buf_q),
  .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/mp_uart_bench.sv
module mp_uart_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rxd = 1'b1;
  logic       txd, rx_irq, tx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic prev_irq = 1'b0;

  always #10 clk = ~clk;

  mp_uart u_mp_uart (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic send_rx(input logic [7:0] d, input bit nine, input logic b9,
                         input logic stopv, input int glitch_bit);
    logic [10:0] fr;
    int n;
    n = nine ? 11 : 10;
    fr = nine ? {stopv, b9, d, 1'b0} : {1'b0, stopv, d, 1'b0};
    for (int i = 0; i < n; i++)
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        rxd = fr[i] ^ (i == glitch_bit && c == 10);
      end
    @(negedge clk);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  // Scoreboard monitor: each receive-flag rise pops one expected byte.
  always @(negedge clk) begin
    if (rst_n && rx_irq && !prev_irq) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected accept", {8'h0, reg_rdata}, 16'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(reg_rdata == e, "R4 received byte", {8'h0, reg_rdata}, {8'h0, e});
      end
    end
    prev_irq <= rx_irq;
  end

  task automatic tx_capture(input int nbits, output logic [8:0] got,
                            output logic irq_before, output logic irq_stop, output logic line_stop);
    got = '0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (7) @(negedge clk);
    chk(txd == 1'b0, "R2 start bit", {15'h0, txd}, 16'h0);
    for (int i = 0; i < nbits; i++) begin
      repeat (16) @(negedge clk);
      got[i] = txd;
    end
    irq_before = tx_irq;
    repeat (16) @(negedge clk);
    irq_stop = tx_irq;
    line_stop = txd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [8:0] got;
    logic ib, is, ls;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(txd == 1'b1, "R1 txd idle", {15'h0, txd}, 16'h1);
    chk(!rx_irq && !tx_irq, "R1 irqs low", {14'h0, rx_irq, tx_irq}, 16'h0);
    rd(2'd1, v);
    chk(v == 8'h00, "R1 ctrl reset", {8'h0, v}, 16'h0);

    // R4: 8-bit receive
    wr(2'd1, 8'h20);
    exp_q.push_back(8'hA5);
    send_rx(8'hA5, 0, 0, 1, -1);
    rd(2'd1, v);
    chk(v == 8'h31, "R4 ctrl after frame", {8'h0, v}, 16'h0031);
    wr(2'd1, 8'h20);
    exp_q.push_back(8'h3C);
    send_rx(8'h3C, 0, 0, 1, -1);
    chk(rx_irq, "R4 second frame flag", {15'h0, rx_irq}, 16'h1);

    // R11: overrun drops frame
    send_rx(8'h77, 0, 0, 1, -1);
    rd(2'd0, v);
    chk(v == 8'h3C, "R11 buffer kept", {8'h0, v}, 16'h003C);
    wr(2'd1, 8'h20);

    // R9: framing error sticky
    exp_q.push_back(8'h81);
    send_rx(8'h81, 0, 0, 0, -1);
    rd(2'd1, v);
    chk(v[2] == 1'b1 && v[4] == 1'b0, "R9 ferr set", {8'h0, v}, 16'h0025);
    wr(2'd1, 8'h24);
    rd(2'd1, v);
    chk(v[2] == 1'b1, "R9 ferr kept on write 1", {8'h0, v}, 16'h0024);
    wr(2'd1, 8'h20);
    rd(2'd1, v);
    chk(v[2] == 1'b0, "R9 ferr cleared", {8'h0, v}, 16'h0020);

    // R5: 9-bit receive
    wr(2'd1, 8'h60);
    exp_q.push_back(8'h42);
    send_rx(8'h42, 1, 1, 1, -1);
    rd(2'd1, v);
    chk(v[4] == 1'b1, "R5 ninth bit 1", {8'h0, v}, 16'h0071);
    wr(2'd1, 8'h60);
    exp_q.push_back(8'h99);
    send_rx(8'h99, 1, 0, 1, -1);
    rd(2'd1, v);
    chk(v[4] == 1'b0 && v[0], "R5 ninth bit 0", {8'h0, v}, 16'h0061);

    // R7 / R6 / R8: address filtering
    wr(2'd2, 8'h35);
    wr(2'd3, 8'h0F);
    wr(2'd1, 8'hE0);
    exp_q.push_back(8'h65);
    send_rx(8'h65, 1, 1, 1, -1);
    chk(rx_irq, "R7 masked match accepted", {15'h0, rx_irq}, 16'h1);
    wr(2'd1, 8'hE0);
    send_rx(8'h36, 1, 1, 1, -1);
    chk(!rx_irq, "R7 mismatch dropped", {15'h0, rx_irq}, 16'h0);
    send_rx(8'h65, 1, 0, 1, -1);
    chk(!rx_irq, "R6 ninth bit 0 dropped", {15'h0, rx_irq}, 16'h0);
    rd(2'd0, v);
    chk(v == 8'h65, "R6 buffer unchanged", {8'h0, v}, 16'h0065);
    exp_q.push_back(8'hFF);
    send_rx(8'hFF, 1, 1, 1, -1);
    chk(rx_irq, "R8 broadcast FF accepted", {15'h0, rx_irq}, 16'h1);
    wr(2'd1, 8'hE0);
    exp_q.push_back(8'h7F);
    send_rx(8'h7F, 1, 1, 1, -1);
    chk(rx_irq, "R8 broadcast 7F accepted", {15'h0, rx_irq}, 16'h1);
    wr(2'd1, 8'hE0);
    send_rx(8'h3E, 1, 1, 1, -1);
    chk(!rx_irq, "R8 near-broadcast dropped", {15'h0, rx_irq}, 16'h0);

    // R10: noise start and glitch
    wr(2'd1, 8'h20);
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
    chk(!rx_irq, "R10 short start discarded", {15'h0, rx_irq}, 16'h0);
    exp_q.push_back(8'hC3);
    send_rx(8'hC3, 0, 0, 1, 3);
    chk(rx_irq, "R10 glitched frame received", {15'h0, rx_irq}, 16'h1);
    wr(2'd1, 8'h00);

    // R2 / R3: transmit 8-bit, with ignored write mid-frame
    fork
      wr(2'd0, 8'h96);
      tx_capture(8, got, ib, is, ls);
      begin repeat (50) @(negedge clk); wr(2'd0, 8'h0F); end
    join
    chk(got[7:0] == 8'h96, "R2 tx data LSB first", {7'h0, got}, 16'h0096);
    chk(!ib, "R3 tx flag low before stop", {15'h0, ib}, 16'h0);
    chk(is && ls, "R3 tx flag with stop bit", {14'h0, is, ls}, 16'h3);
    repeat (60) @(negedge clk);
    chk(txd == 1'b1, "R3 ignored write sent nothing", {15'h0, txd}, 16'h1);

    // R2: 9-bit transmit
    wr(2'd1, 8'h48);
    fork
      wr(2'd0, 8'h3C);
      tx_capture(9, got, ib, is, ls);
    join
    chk(got == 9'h13C, "R2 tx nine bits", {7'h0, got}, 16'h013C);
    chk(is && ls, "R3 tx flag nine-bit", {14'h0, is, ls}, 16'h3);

    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected frames seen", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule